// File: doc/BRIEF.md
# Single-Cycle RISC-V Integer Arithmetic Core

This block is a 32-bit single-cycle core that runs the register-register and register-immediate arithmetic and logic instructions of the RISC-V base integer set. In every clock cycle it fetches one instruction from an external combinational instruction memory at the current program counter. It decodes the instruction, reads two source registers and forms operand B. Operand B is either the second source register or the generated immediate. The ALU computes the result, and the result is written into the destination register at the next rising edge.

The program counter steps by four bytes every cycle. A decoder turns the opcode, funct3 and instruction bit 30 into four control outputs: the immediate format select, the register write enable, the operand-B select and the ALU operation. The immediate generator builds all five base-set immediate formats from a 3-bit select, so the core can later be extended with loads, stores, branches and jumps. The write-back bus (enable, destination index, data) is brought out at the ports so that the effect of each instruction can be observed in the cycle it executes.

The core has no states beyond the program counter. Reset loads address 0, and after that the core advances by one instruction on each edge.

Top module: `rv_arith_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter (`imem_addr`) to 0 at the clock edge, and holds it at 0 while `rst` stays high.
- R2: Out of reset, `imem_addr` increases by 4 at every rising edge. The instruction presented on `imem_data` during a cycle is the one executed in that cycle.
- R3: For opcode 0110011 the result of rs1 (inst[19:15]) and rs2 (inst[24:20]) appears on `wb_data`, with `wb_en`=1 and `wb_rd`=inst[11:7]. It is written into that register at the rising edge. funct3 (inst[14:12]) 000 is add, or subtract when inst[30]=1. funct3 100 is xor, 110 is or and 111 is and.
- R4: funct3 010 is a signed less-than and funct3 011 is an unsigned less-than. Each gives 1 or 0. The immediate forms compare against the sign-extended immediate, also for the unsigned form.
- R5: funct3 001 shifts left logically. funct3 101 shifts right, logically when inst[30]=0 and arithmetically when inst[30]=1. The shift amount is the low 5 bits of operand B: rs2 for opcode 0110011, inst[24:20] for opcode 0010011.
- R6: For opcode 0010011, operand B is inst[31:20] sign-extended to 32 bits. With funct3 000 the operation is always an add, even when inst[30]=1.
- R7: Register 0 always reads as zero. A write addressed to it is shown on the write-back bus but leaves it unchanged.
- R8: Any opcode other than 0110011 or 0010011 drives `wb_en`=0 and changes no register. The program counter still advances by 4.
- R9: The immediate generator output for select 000 is inst[31:20] sign-extended. For select 001 it is {inst[31:25], inst[11:7]} sign-extended.
- R10: For select 010 the output is {inst[31], inst[7], inst[30:25], inst[11:8], 0}, sign-extended from bit 12. For select 100 it is {inst[31], inst[19:12], inst[20], inst[30:21], 0}, sign-extended from bit 20.
- R11: For select 011 the output is inst[31:12] in bits 31..12, with bits 11..0 zero. Select codes 101 to 111 give 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (program counter) |
| imem_data | input | 32 | Instruction word read combinationally from `imem_addr` |
| wb_en | output | 1 | Register write enable of the current instruction |
| wb_rd | output | 5 | Destination register index |
| wb_data | output | 32 | ALU result written to the destination register |

## Verification
The embedded assertions check on every cycle that:
- the program counter steps by four;
- an enabled write to a nonzero register lands in that register on the next edge;
- the immediate-add decode sets the add operation, immediate operand and write enable;
- foreign opcodes never raise the write enable;
- comparison results are 0 or 1, arithmetic right shifts keep the sign, and the immediate generator gives zero low bits and the correct sign bit.

Only the directed programs can show that the values computed are actually right:
- operand B comes from rs2 or from the immediate as each opcode requires;
- register 0 stays zero after a write to it;
- a skipped instruction leaves its destination untouched;
- every immediate format places each field correctly.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
    localparam int XLEN = 32;
    localparam int ILEN = 32;
    localparam int RAW  = 5;
    localparam int NREG = 1 << RAW;

    localparam logic [6:0] OPC_REG = 7'b0110011;
    localparam logic [6:0] OPC_IMM = 7'b0010011;

    typedef enum logic [2:0] {
        IMM_I = 3'b000,
        IMM_S = 3'b001,
        IMM_B = 3'b010,
        IMM_U = 3'b011,
        IMM_J = 3'b100
    } imm_sel_e;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
        ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR,  ALU_AND
    } alu_op_e;
endpackage

// File: rtl/rvc_decode.sv
module rvc_decode
    import rvc_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic       alt,
    output imm_sel_e   imm_sel,
    output logic       reg_wen,
    output logic       b_sel,
    output alu_op_e    alu_sel
);
    logic is_reg;
    logic is_imm;

    assign is_reg = (opcode == OPC_REG);
    assign is_imm = (opcode == OPC_IMM);

    always_comb begin
        imm_sel = IMM_I;
        reg_wen = is_reg | is_imm;
        b_sel   = is_imm;
        unique case (funct3)
            3'b000:  alu_sel = (is_reg && alt) ? ALU_SUB : ALU_ADD;
            3'b001:  alu_sel = ALU_SLL;
            3'b010:  alu_sel = ALU_SLT;
            3'b011:  alu_sel = ALU_SLTU;
            3'b100:  alu_sel = ALU_XOR;
            3'b101:  alu_sel = alt ? ALU_SRA : ALU_SRL;
            3'b110:  alu_sel = ALU_OR;
            default: alu_sel = ALU_AND;
        endcase
    end

    always_comb begin
        // R6
        if (opcode == OPC_IMM && funct3 == 3'b000)
            addi_ctrl_chk: assert (alu_sel == ALU_ADD && b_sel && reg_wen && imm_sel == IMM_I);
        // R8
        if (opcode != OPC_REG && opcode != OPC_IMM)
            foreign_op_chk: assert (!reg_wen);
    end
endmodule

// File: rtl/rvc_immgen.sv
module rvc_immgen
    import rvc_pkg::*;
(
    input  logic [ILEN-1:0] inst,
    input  logic [2:0]      sel,
    output logic [XLEN-1:0] imm
);
    always_comb begin
        unique case (sel)
            IMM_I:   imm = {{(XLEN-11){inst[31]}}, inst[30:20]};
            IMM_S:   imm = {{(XLEN-11){inst[31]}}, inst[30:25], inst[11:7]};
            IMM_B:   imm = {{(XLEN-12){inst[31]}}, inst[7], inst[30:25], inst[11:8], 1'b0};
            IMM_U:   imm = {inst[31:12], 12'b0};
            IMM_J:   imm = {{(XLEN-20){inst[31]}}, inst[19:12], inst[20], inst[30:21], 1'b0};
            default: imm = '0;
        endcase
    end

    always_comb begin
        // R10
        if (sel == IMM_B || sel == IMM_J)
            even_target_chk: assert (imm[0] == 1'b0);
        // R11
        if (sel == IMM_U)
            upper_low_zero_chk: assert (imm[11:0] == 12'b0);
        // R9
        if (sel == IMM_I || sel == IMM_S || sel == IMM_B || sel == IMM_J)
            sign_bit_chk: assert (imm[XLEN-1] == inst[31]);
    end
endmodule

// File: rtl/rvc_regfile.sv
module rvc_regfile
    import rvc_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int AW = RAW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst && we && wa != '0)
            regs[wa] <= wd;
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

    // R3
    write_land_chk: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0) |=> regs[$past(wa)] == $past(wd));
endmodule

// File: rtl/rvc_alu.sv
module rvc_alu
    import rvc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  y
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] shamt;
    assign shamt = b[SHW-1:0];

    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_SLL:  y = a << shamt;
            ALU_SLT:  y = {{(W-1){1'b0}}, $signed(a) < $signed(b)};
            ALU_SLTU: y = {{(W-1){1'b0}}, a < b};
            ALU_XOR:  y = a ^ b;
            ALU_SRL:  y = a >> shamt;
            ALU_SRA:  y = W'($signed(a) >>> shamt);
            ALU_OR:   y = a | b;
            default:  y = a & b;
        endcase
    end

    always_comb begin
        // R4
        if (op == ALU_SLT || op == ALU_SLTU)
            cmp_bool_chk: assert (y[W-1:1] == '0);
        // R5
        if (op == ALU_SRA)
            sra_sign_chk: assert (y[W-1] == a[W-1]);
    end
endmodule

// File: rtl/rv_arith_core.sv
module rv_arith_core
    import rvc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [ILEN-1:0] imem_data,
    output logic            wb_en,
    output logic [RAW-1:0]  wb_rd,
    output logic [XLEN-1:0] wb_data
);
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(ILEN / 8);

    logic [XLEN-1:0] pc;
    logic [1:0]      age;
    imm_sel_e        imm_sel;
    logic            reg_wen;
    logic            b_sel;
    alu_op_e         alu_sel;
    logic [XLEN-1:0] rs1_val;
    logic [XLEN-1:0] rs2_val;
    logic [XLEN-1:0] imm;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc + PC_STEP;
    end

    always_ff @(posedge clk) begin
        if (rst)              age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    assign imem_addr = pc;

    rvc_decode u_dec (
        .opcode (imem_data[6:0]),
        .funct3 (imem_data[14:12]),
        .alt    (imem_data[30]),
        .imm_sel(imm_sel),
        .reg_wen(reg_wen),
        .b_sel  (b_sel),
        .alu_sel(alu_sel)
    );

    rvc_regfile u_rf (
        .clk(clk),
        .rst(rst),
        .ra1(imem_data[19:15]),
        .ra2(imem_data[24:20]),
        .rd1(rs1_val),
        .rd2(rs2_val),
        .we (reg_wen),
        .wa (imem_data[11:7]),
        .wd (alu_y)
    );

    rvc_immgen u_imm (
        .inst(imem_data),
        .sel (imm_sel),
        .imm (imm)
    );

    assign alu_b = b_sel ? imm : rs2_val;

    rvc_alu u_alu (
        .op(alu_sel),
        .a (rs1_val),
        .b (alu_b),
        .y (alu_y)
    );

    assign wb_en   = reg_wen;
    assign wb_rd   = imem_data[11:7];
    assign wb_data = alu_y;

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0) |-> imem_addr == $past(imem_addr) + PC_STEP);
endmodule

// File: tb/sim_rv_arith_core.sv
module sim_rv_arith_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr;
    logic [31:0] imem_data;
    logic        wb_en;
    logic [4:0]  wb_rd;
    logic [31:0] wb_data;

    logic [31:0] imem [64];
    logic [31:0] mreg [32];

    logic [31:0] ig_inst;
    logic [2:0]  ig_sel;
    logic [31:0] ig_imm;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign imem_data = imem[imem_addr[7:2]];

    rv_arith_core u0 (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
        .wb_en(wb_en), .wb_rd(wb_rd), .wb_data(wb_data)
    );

    rvc_immgen u_ig (.inst(ig_inst), .sel(ig_sel), .imm(ig_imm));

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, 7'b0110011};
    endfunction

    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                          input logic [2:0] f3, input logic [4:0] rd);
        return {imm, rs1, f3, rd, 7'b0010011};
    endfunction

    function automatic logic [31:0] mread(input logic [4:0] idx);
        return (idx == 5'd0) ? 32'd0 : mreg[idx];
    endfunction

    function automatic logic [31:0] ref_result(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] r2);
        logic        isr;
        logic [31:0] b;
        isr = (ins[6:0] == 7'b0110011);
        b   = isr ? r2 : {{20{ins[31]}}, ins[31:20]};
        case (ins[14:12])
            3'd0:    return (isr && ins[30]) ? a - b : a + b;
            3'd1:    return a << b[4:0];
            3'd2:    return {31'b0, $signed(a) < $signed(b)};
            3'd3:    return {31'b0, a < b};
            3'd4:    return a ^ b;
            3'd5:    return ins[30] ? 32'($signed(a) >>> b[4:0]) : a >> b[4:0];
            3'd6:    return a | b;
            default: return a & b;
        endcase
    endfunction

    task automatic clear_imem();
        for (int k = 0; k < 64; k++) imem[k] = 32'd0;
    endtask

    task automatic run_prog(input int n, input string tag);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic [31:0] ins;
            logic [31:0] expd;
            logic        en;
            #1;
            ins = imem[i];
            chk("R2", "pc", imem_addr, 32'(i * 4));
            en = (ins[6:0] == 7'b0110011) || (ins[6:0] == 7'b0010011);
            chk(tag, "wb_en", {31'b0, wb_en}, {31'b0, en});
            if (en) begin
                expd = ref_result(ins, mread(ins[19:15]), mread(ins[24:20]));
                chk(tag, "wb_rd", {27'b0, wb_rd}, {27'b0, ins[11:7]});
                chk(tag, "wb_data", wb_data, expd);
                if (ins[11:7] != 5'd0) mreg[ins[11:7]] = expd;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        clear_imem();
        imem[0] = enc_i(12'd1, 5'd0, 3'b000, 5'd1);
        imem[1] = enc_i(12'd2, 5'd0, 3'b000, 5'd2);
        imem[2] = enc_i(12'd3, 5'd0, 3'b000, 5'd3);
        run_prog(3, "R1");
        #1;
        chk("R1", "pc before reset", imem_addr, 32'd12);
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", "pc after reset edge", imem_addr, 32'd0);
        @(negedge clk);
        #1;
        chk("R1", "pc held in reset", imem_addr, 32'd0);
    endtask

    task automatic t_arith();
        clear_imem();
        imem[0] = enc_i(12'd100, 5'd0, 3'b000, 5'd1);
        imem[1] = enc_i(12'hFF9, 5'd0, 3'b000, 5'd2);
        imem[2] = enc_r(7'b0000000, 5'd2, 5'd1, 3'b000, 5'd3);
        imem[3] = enc_r(7'b0100000, 5'd2, 5'd1, 3'b000, 5'd4);
        imem[4] = enc_r(7'b0000000, 5'd2, 5'd1, 3'b100, 5'd5);
        imem[5] = enc_r(7'b0000000, 5'd2, 5'd1, 3'b110, 5'd6);
        imem[6] = enc_r(7'b0000000, 5'd2, 5'd1, 3'b111, 5'd7);
        imem[7] = enc_r(7'b0000000, 5'd4, 5'd3, 3'b000, 5'd8);
        run_prog(8, "R3");
        chk("R3", "sub result", mreg[4], 32'd107);
        chk("R3", "add result", mreg[8], 32'd200);
    endtask

    task automatic t_compare();
        clear_imem();
        imem[0] = enc_i(12'd100, 5'd0, 3'b000, 5'd1);
        imem[1] = enc_i(12'hFF9, 5'd0, 3'b000, 5'd2);
        imem[2] = enc_r(7'b0000000, 5'd1, 5'd2, 3'b010, 5'd3);
        imem[3] = enc_r(7'b0000000, 5'd1, 5'd2, 3'b011, 5'd4);
        imem[4] = enc_i(12'hFFD, 5'd2, 3'b010, 5'd5);
        imem[5] = enc_i(12'hFFF, 5'd1, 3'b011, 5'd6);
        imem[6] = enc_r(7'b0000000, 5'd2, 5'd1, 3'b010, 5'd7);
        run_prog(7, "R4");
        chk("R4", "signed less", mreg[3], 32'd1);
        chk("R4", "unsigned not less", mreg[4], 32'd0);
        chk("R4", "sltiu sign-extended", mreg[6], 32'd1);
    endtask

    task automatic t_shift();
        clear_imem();
        imem[0] = enc_i(12'hF00, 5'd0, 3'b000, 5'd1);
        imem[1] = enc_i(12'd36,  5'd0, 3'b000, 5'd2);
        imem[2] = enc_r(7'b0000000, 5'd2, 5'd1, 3'b001, 5'd3);
        imem[3] = enc_r(7'b0000000, 5'd2, 5'd1, 3'b101, 5'd4);
        imem[4] = enc_r(7'b0100000, 5'd2, 5'd1, 3'b101, 5'd5);
        imem[5] = enc_i(12'h408, 5'd1, 3'b101, 5'd6);
        imem[6] = enc_i(12'h008, 5'd1, 3'b101, 5'd7);
        imem[7] = enc_i(12'h004, 5'd1, 3'b001, 5'd8);
        run_prog(8, "R5");
        chk("R5", "sll by low bits", mreg[3], 32'hFFFFF000);
        chk("R5", "srl", mreg[4], 32'h0FFFFFF0);
        chk("R5", "sra", mreg[5], 32'hFFFFFFF0);
        chk("R5", "srai", mreg[6], 32'hFFFFFFFF);
        chk("R5", "srli", mreg[7], 32'h00FFFFFF);
    endtask

    task automatic t_addi();
        clear_imem();
        imem[0] = enc_i(12'h7FF, 5'd0, 3'b000, 5'd1);
        imem[1] = enc_i(12'h800, 5'd1, 3'b000, 5'd2);
        imem[2] = enc_i(12'h400, 5'd0, 3'b000, 5'd3);
        imem[3] = enc_i(12'hC00, 5'd3, 3'b000, 5'd4);
        run_prog(4, "R6");
        chk("R6", "max positive imm", mreg[1], 32'd2047);
        chk("R6", "most negative imm", mreg[2], 32'hFFFFFFFF);
        chk("R6", "bit30 set is add", mreg[3], 32'd1024);
        chk("R6", "sum to zero", mreg[4], 32'd0);
    endtask

    task automatic t_x0();
        clear_imem();
        imem[0] = enc_i(12'd55, 5'd0, 3'b000, 5'd0);
        imem[1] = enc_r(7'b0000000, 5'd0, 5'd0, 3'b000, 5'd1);
        imem[2] = enc_i(12'd5, 5'd0, 3'b000, 5'd2);
        run_prog(3, "R7");
        chk("R7", "x0 read after write", mreg[1], 32'd0);
        chk("R7", "x0 as source", mreg[2], 32'd5);
    endtask

    task automatic t_foreign();
        clear_imem();
        imem[0] = enc_i(12'd9, 5'd0, 3'b000, 5'd1);
        imem[1] = {12'd4, 5'd0, 3'b010, 5'd1, 7'b0000011};
        imem[2] = {7'd0, 5'd1, 5'd0, 3'b010, 5'd8, 7'b0100011};
        imem[3] = {20'hABCDE, 5'd1, 7'b0110111};
        imem[4] = 32'd0;
        imem[5] = enc_r(7'b0000000, 5'd0, 5'd1, 3'b000, 5'd2);
        run_prog(6, "R8");
        chk("R8", "x1 untouched", mreg[2], 32'd9);
    endtask

    task automatic ig_chk(input string tag, input logic [31:0] ins, input logic [2:0] sel, input logic [31:0] exp);
        ig_inst = ins;
        ig_sel  = sel;
        #1;
        chk(tag, "immediate", ig_imm, exp);
    endtask

    task automatic t_immgen();
        ig_chk("R9",  32'hFEDCBA98, 3'b000, 32'hFFFFFFED);
        ig_chk("R9",  32'hFEDCBA98, 3'b001, 32'hFFFFFFF5);
        ig_chk("R9",  32'h01234567, 3'b000, 32'h00000012);
        ig_chk("R9",  32'h01234567, 3'b001, 32'h0000000A);
        ig_chk("R10", 32'hFEDCBA98, 3'b010, 32'hFFFFFFF4);
        ig_chk("R10", 32'hFEDCBA98, 3'b100, 32'hFFFCBFEC);
        ig_chk("R10", 32'h01234567, 3'b010, 32'h0000000A);
        ig_chk("R10", 32'h01234567, 3'b100, 32'h00034012);
        ig_chk("R11", 32'hFEDCBA98, 3'b011, 32'hFEDCB000);
        ig_chk("R11", 32'h01234567, 3'b011, 32'h01234000);
        ig_chk("R11", 32'hFEDCBA98, 3'b111, 32'h00000000);
    endtask

    initial begin
        for (int k = 0; k < 32; k++) mreg[k] = 32'd0;
        ig_inst = 32'd0;
        ig_sel  = 3'b000;
        clear_imem();
        t_reset();
        t_arith();
        t_compare();
        t_shift();
        t_addi();
        t_x0();
        t_foreign();
        t_immgen();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule